// File: doc/BRIEF.md
# Bandpass Mismatch-Shaping Tree Switching Node

This block is one node of a tree-structured encoder that decides which unit cells of a thermometric feedback DAC are turned on. It receives an unsigned cell count `y` in the range 0..2^K, where K is the layer of the node in the tree. It splits that count into an upper half `(y+S)/2` and a lower half `(y-S)/2`, which are passed to the two child nodes of the next layer. The signed switching step S sets how unevenly the count is split. It is chosen each cycle so that the mismatch error injected by this split is pushed away from a band centred at a quarter of the sample rate.

S is produced by a small quantizer. The quantizer looks at the output V of a digital loop filter, and that filter is fed with −S. The filter is two cascaded resonators, each with response −z^-2/(1+z^-2), which gives fourth-order bandpass shaping. The quantizer may take a step of ±2 on even counts that are not at either end of the range, so the loop keeps control even when the count stays even for long stretches. The filter registers saturate at the limits of a signed word and never wrap. V leaves the block on a debug port. The split is combinational from the current count and the registered filter state, and the filter advances on every clock edge.

Top module: `dem_tree_switch`

## Requirements
- R1: In every cycle `y_up + y_lo` equals `y_in`, so no cell count is created or lost in the split.
- R2: Neither `y_up` nor `y_lo` ever exceeds 2^(K-1).
- R3: For an odd `y_in`, the step S = `y_up - y_lo` is +1 when `v_dbg` > 0 and −1 when `v_dbg` < 0. When `v_dbg` = 0 the tie goes to +1, because a zero step cannot split an odd count into whole halves.
- R4: For an even `y_in` with 0 < `y_in` < 2^K, S is +2 when `v_dbg` > 0, −2 when `v_dbg` < 0, and 0 when `v_dbg` = 0.
- R5: For `y_in` = 0 or `y_in` = 2^K, S is 0 and both outputs equal `y_in/2`, whatever the filter holds.
- R6: With S[n] = `y_up - y_lo` in cycle n, the first resonator computes a[n] = S[n-2] − a[n-2], and `v_dbg` follows V[n] = −a[n-2] − V[n-2]. Both take effect in the same cycle as the decision they feed, and values before reset count as 0.
- R7: Both a[n] and V[n] are clamped to the range −2^(RES_W-1) .. 2^(RES_W-1)−1 (−32..31 for the default RES_W = 6) instead of wrapping.
- R8: A synchronous active-high `rst` clears all filter state, so `v_dbg` reads 0 in the first cycle after reset and the first odd count splits with step +1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; filter state advances on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the filter state |
| y_in | input | K+1 | Unsigned cell count, 0..2^K |
| y_up | output | K | Upper half count, (y_in+S)/2 |
| y_lo | output | K | Lower half count, (y_in−S)/2 |
| v_dbg | output | RES_W | Signed loop-filter output V, for debug |

## Verification
The bench uses K = 3, which is the top layer of an eight-cell tree, with the default 6-bit filter word and two resonators. With these values the count covers all nine levels from 0 to 8. Both extremes, every odd value and every interior even value therefore appear with both signs of V and with V = 0. One stretch drives an active burst and then holds the count at 0. The second resonator then grows with no feedback and reaches its clamp limits, so saturation is exercised. A reset in the middle of the run shows that the state is cleared.

// File: rtl/dem_sb_pkg.sv
package dem_sb_pkg;

    // Signed switching step; the encoding equals the step value in 3-bit two's complement.
    typedef enum logic [2:0] {
        STEP_NEG2 = 3'b110,
        STEP_NEG1 = 3'b111,
        STEP_ZERO = 3'b000,
        STEP_POS1 = 3'b001,
        STEP_POS2 = 3'b010
    } step_e;

    // Class of the incoming count
    typedef enum logic [1:0] {
        CLS_EDGE = 2'd0,   // 0 or full scale
        CLS_ODD  = 2'd1,
        CLS_EVEN = 2'd2    // even and strictly inside the range
    } cls_e;

    typedef struct packed {
        cls_e cls;
        logic pos;   // filter output above zero
        logic neg;   // filter output below zero
    } qin_t;

    function automatic int clamp_int(input int val, input int lo, input int hi);
        if (val > hi)      return hi;
        else if (val < lo) return lo;
        else               return val;
    endfunction

endpackage

// File: rtl/dem_quantizer.sv
module dem_quantizer
    import dem_sb_pkg::*;
#(
    parameter int K     = 3,
    parameter int RES_W = 6
) (
    input  logic [K:0]              y,
    input  logic signed [RES_W-1:0] v,
    output step_e                   step
);
    localparam logic [K:0] FULL = (K+1)'(1) << K;

    qin_t q;

    always_comb begin
        if (y == '0 || y == FULL) q.cls = CLS_EDGE;
        else if (y[0])            q.cls = CLS_ODD;
        else                      q.cls = CLS_EVEN;
        q.pos = (v > 0);
        q.neg = (v < 0);
    end

    always_comb begin
        step = STEP_ZERO;
        unique case (q.cls)
            CLS_ODD:  step = q.neg ? STEP_NEG1 : STEP_POS1;   // zero filter ties to +1
            CLS_EVEN: begin
                if (q.pos)      step = STEP_POS2;
                else if (q.neg) step = STEP_NEG2;
                else            step = STEP_ZERO;
            end
            default:  step = STEP_ZERO;
        endcase
    end
endmodule

// File: rtl/dem_splitter.sv
module dem_splitter
    import dem_sb_pkg::*;
#(
    parameter int K = 3
) (
    input  logic [K:0]   y,
    input  step_e        step,
    output logic [K-1:0] half_up,
    output logic [K-1:0] half_lo
);
    localparam int SW = K + 3;

    logic signed [2:0]    s_val;
    logic signed [SW-1:0] y_ext;
    logic signed [SW-1:0] sum_up;
    logic signed [SW-1:0] sum_lo;

    always_comb begin
        s_val   = $signed(3'(step));
        y_ext   = $signed({2'b00, y});
        sum_up  = y_ext + SW'(s_val);
        sum_lo  = y_ext - SW'(s_val);
        half_up = K'(sum_up >>> 1);
        half_lo = K'(sum_lo >>> 1);
    end
endmodule

// File: rtl/dem_resonator.sv
module dem_resonator
    import dem_sb_pkg::*;
#(
    parameter int W = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic signed [W-1:0] x,
    output logic signed [W-1:0] r
);
    localparam int LO = -(2 ** (W - 1));
    localparam int HI = (2 ** (W - 1)) - 1;

    logic signed [W-1:0] x_d1, x_d2;
    logic signed [W-1:0] r_d1, r_d2;

    // r[n] = -x[n-2] - r[n-2], clamped
    always_comb r = W'(clamp_int(-int'(x_d2) - int'(r_d2), LO, HI));

    always_ff @(posedge clk) begin
        if (rst) begin
            x_d1 <= '0;
            x_d2 <= '0;
            r_d1 <= '0;
            r_d2 <= '0;
        end else begin
            x_d1 <= x;
            x_d2 <= x_d1;
            r_d1 <= r;
            r_d2 <= r_d1;
        end
    end
endmodule

// File: rtl/dem_tree_switch.sv
module dem_tree_switch
    import dem_sb_pkg::*;
#(
    parameter int K       = 3,
    parameter int RES_W   = 6,
    parameter int NUM_RES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [K:0]              y_in,
    output logic [K-1:0]            y_up,
    output logic [K-1:0]            y_lo,
    output logic signed [RES_W-1:0] v_dbg
);
    step_e               step;
    logic signed [2:0]   s_val;
    logic signed [RES_W-1:0] neg_s;
    logic signed [RES_W-1:0] st_in  [NUM_RES];
    logic signed [RES_W-1:0] st_out [NUM_RES];

    always_comb begin
        s_val = $signed(3'(step));
        neg_s = -(RES_W'(s_val));
    end

    for (genvar g = 0; g < NUM_RES; g++) begin : g_res
        if (g == 0) begin : g_head
            assign st_in[g] = neg_s;
        end else begin : g_chain
            assign st_in[g] = st_out[g-1];
        end
        dem_resonator #(.W(RES_W)) res_i (
            .clk (clk),
            .rst (rst),
            .x   (st_in[g]),
            .r   (st_out[g])
        );
    end

    assign v_dbg = st_out[NUM_RES-1];

    dem_quantizer #(.K(K), .RES_W(RES_W)) quant_i (
        .y    (y_in),
        .v    (v_dbg),
        .step (step)
    );

    dem_splitter #(.K(K)) split_i (
        .y       (y_in),
        .step    (step),
        .half_up (y_up),
        .half_lo (y_lo)
    );
endmodule

// File: rtl/dem_tree_switch_chk.sv
module dem_tree_switch_chk #(
    parameter int K     = 3,
    parameter int RES_W = 6
) (
    input logic                    clk,
    input logic                    rst,
    input logic [K:0]              y_in,
    input logic [K-1:0]            y_up,
    input logic [K-1:0]            y_lo,
    input logic signed [RES_W-1:0] v_dbg
);
    localparam int HALF = 2 ** (K - 1);
    localparam int FULL = 2 ** K;

    int diff;
    always_comb diff = int'(y_up) - int'(y_lo);

    // R1
    conservation_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(y_up) + int'(y_lo)) == int'(y_in));

    // R2
    half_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(y_up) <= HALF) && (int'(y_lo) <= HALF));

    // R3
    odd_step_chk: assert property (@(posedge clk) disable iff (rst)
        y_in[0] |-> (diff == ((v_dbg < 0) ? -1 : 1)));

    // R4
    even_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!y_in[0] && int'(y_in) != 0 && int'(y_in) != FULL)
        |-> (diff == ((v_dbg > 0) ? 2 : ((v_dbg < 0) ? -2 : 0))));

    // R5
    edge_split_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(y_in) == 0 || int'(y_in) == FULL) |-> (y_up == y_lo));

    // R8
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (v_dbg == '0));
endmodule

bind dem_tree_switch dem_tree_switch_chk #(.K(K), .RES_W(RES_W)) chk_i (
    .clk   (clk),
    .rst   (rst),
    .y_in  (y_in),
    .y_up  (y_up),
    .y_lo  (y_lo),
    .v_dbg (v_dbg)
);

// File: tb/dem_tree_switch_tb.sv
module dem_tree_switch_tb_top;
    localparam int K     = 3;
    localparam int RES_W = 6;
    localparam int FULL  = 8;
    localparam int HALF  = 4;
    localparam int VMAX  = 31;
    localparam int VMIN  = -32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [K:0]       y_in = '0;
    logic [K-1:0]     y_up;
    logic [K-1:0]     y_lo;
    logic signed [RES_W-1:0] v_dbg;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    bit hit_sat = 1'b0;

    // model history: index 0 = one cycle ago, 1 = two cycles ago
    int m_s [2];
    int m_a [2];
    int m_v [2];

    always #4 clk = ~clk;

    dem_tree_switch #(.K(K), .RES_W(RES_W), .NUM_RES(2)) dut_i (
        .clk(clk), .rst(rst), .y_in(y_in), .y_up(y_up), .y_lo(y_lo), .v_dbg(v_dbg)
    );

    function automatic int lim(input int x);
        return (x > VMAX) ? VMAX : ((x < VMIN) ? VMIN : x);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 2; i++) begin
            m_s[i] = 0; m_a[i] = 0; m_v[i] = 0;
        end
    endtask

    // Apply one count for one cycle, compare against the model, advance the model.
    task automatic step_cycle(input int y);
        int v_exp, a_exp, s_exp, up, lo;
        string rule;
        @(negedge clk);
        y_in = (K+1)'(y);
        #1;
        v_exp = lim(-m_a[1] - m_v[1]);         // R6, R7
        a_exp = lim(m_s[1] - m_a[1]);
        if (y == 0 || y == FULL) begin
            s_exp = 0; rule = "R5";
        end else if (y % 2 == 1) begin
            s_exp = (v_exp < 0) ? -1 : 1; rule = "R3";
        end else begin
            s_exp = (v_exp > 0) ? 2 : ((v_exp < 0) ? -2 : 0); rule = "R4";
        end
        up = (y + s_exp) / 2;
        lo = (y - s_exp) / 2;
        if (v_exp == VMAX || v_exp == VMIN) hit_sat = 1'b1;
        check("R6/R7 v_dbg", int'(v_dbg), v_exp);
        check({rule, " y_up"}, int'(y_up), up);
        check({rule, " y_lo"}, int'(y_lo), lo);
        check("R1 sum", int'(y_up) + int'(y_lo), y);
        check("R2 bound", ((int'(y_up) <= HALF) && (int'(y_lo) <= HALF)) ? 1 : 0, 1);
        m_s[1] = m_s[0]; m_s[0] = s_exp;
        m_a[1] = m_a[0]; m_a[0] = a_exp;
        m_v[1] = m_v[0]; m_v[0] = v_exp;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        int lfsr;
        model_clear();
        do_reset();
        // R8: state cleared, first odd count splits with +1
        #1;
        check("R8 v after reset", int'(v_dbg), 0);
        step_cycle(3);
        check("R8 first odd split up", int'(y_up), 2);

        // sweep every level twice
        for (int r = 0; r < 2; r++)
            for (int y = 0; y <= FULL; y++) step_cycle(y);
        // hold odd and interior even counts
        for (int i = 0; i < 30; i++) step_cycle(5);
        for (int i = 0; i < 30; i++) step_cycle(6);
        // alternating extremes and mid
        for (int i = 0; i < 20; i++) step_cycle((i % 2) ? FULL : 4);
        // burst then idle at zero: filter runs free and hits the clamp (R7)
        for (int i = 0; i < 12; i++) step_cycle(i % 2 ? 7 : 2);
        for (int i = 0; i < 60; i++) step_cycle(0);
        check("R7 clamp reached", hit_sat ? 1 : 0, 1);
        // pseudo-random counts
        lfsr = 32'h1ACE;
        for (int i = 0; i < 400; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
            step_cycle(lfsr % (FULL + 1));
        end
        // mid-run reset (R8)
        do_reset();
        #1;
        check("R8 v after second reset", int'(v_dbg), 0);
        for (int i = 0; i < 40; i++) step_cycle((i * 3) % (FULL + 1));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule